// File: doc/BRIEF.md
# High-Bandwidth Isochronous Microframe Checker

This block does the per-microframe bookkeeping for an isochronous IN endpoint that moves two or three packets in each microframe. Two event streams come in. The first reports IN transactions that finished, each qualified by an underflow bit. The second reports banks that the CPU has finished filling. An end-of-microframe strobe closes each accounting window.

When the strobe arrives, the block compares both tallies against the configured per-microframe count N. Too few clean transactions means the host missed a token. In that case the block raises a flush flag and emits a one-cycle bank-flush pulse, so the surrounding bank logic can discard its contents and host and device realign. Too few CPU fills raises an underflow-error flag.

Each flag stays set until software writes a one to its clear input. Each flag contributes to the endpoint interrupt only while its enable is high. Token decoding and bank storage live outside this block.

Top module: `hbmf_checker`

## Requirements
- R1: While and directly after reset, `flush_flag`, `uflerr_flag`, `bank_flush` and `ep_irq` are all 0.
- R2: The checks are armed only when `cfg_trans` is 2'd2 or 2'd3. For 2'd0 or 2'd1, an end-of-microframe strobe sets neither flag and produces no `bank_flush` pulse.
- R3: An `in_done` pulse counts as a completed transaction only when `in_underflow` is 0 in the same cycle. A transaction ending in underflow is not counted.
- R4: On the clock edge at which `mf_end` is high with the checks armed, `flush_flag` sets if the completed-transaction count is below `cfg_trans`. `bank_flush` is then high for exactly the one following cycle.
- R5: On the same edge, `uflerr_flag` sets if fewer than `cfg_trans` `cpu_fill` pulses were seen in the microframe.
- R6: An event in the same cycle as `mf_end` belongs to the microframe that is ending. Both tallies restart from zero for the next microframe.
- R7: Both tallies saturate at 3. Four or more events in one microframe still count as 3 and never wrap to a low value.
- R8: Each flag clears only in the cycle after its clear input is 1. A set and a clear in the same cycle leave the flag set. Clearing one flag leaves the other unchanged.
- R9: `ep_irq` is 1 exactly when (`flush_flag` and `flush_en`) or (`uflerr_flag` and `uflerr_en`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trans | input | 2 | Transactions per microframe (2 or 3 arms the checks) |
| in_done | input | 1 | IN transaction finished this cycle |
| in_underflow | input | 1 | The finishing IN transaction underflowed |
| cpu_fill | input | 1 | CPU finished filling one bank this cycle |
| mf_end | input | 1 | End-of-microframe strobe |
| flush_clr | input | 1 | Write-one-to-clear for the flush flag |
| uflerr_clr | input | 1 | Write-one-to-clear for the underflow-error flag |
| flush_en | input | 1 | Interrupt enable for the flush flag |
| uflerr_en | input | 1 | Interrupt enable for the underflow-error flag |
| flush_flag | output | 1 | Sticky flush flag |
| uflerr_flag | output | 1 | Sticky underflow-error flag |
| bank_flush | output | 1 | One-cycle bank flush request |
| ep_irq | output | 1 | Endpoint interrupt |

## Verification
The assertions assume the following about the inputs:
- Reset is held low over the first edges.
- `mf_end` is a strobe.
- `cfg_trans` changes only between microframes.

Under those assumptions, a flush pulse can always be traced to an armed strobe in the previous cycle, and a tally can fall only right after a strobe. The stimulus respects these assumptions. It changes the configuration only after both flags have been cleared and the outputs have settled. It drives every input on the falling edge, and it separates strobes by at least two cycles. Within that envelope, the sweep covers every transaction count from 0 to 4, with and without underflowed transactions, crossed with every fill count and every configuration code.

// File: rtl/hbmf_pkg.sv
package hbmf_pkg;
    localparam int CNT_W = 2;
    localparam int CFG_W = 2;

    typedef struct packed {
        logic bank_flush;
    } top_state_t;

    function automatic logic cfg_armed(input logic [CFG_W-1:0] cfg);
        return (cfg == CFG_W'(2)) || (cfg == CFG_W'(3));
    endfunction
endpackage

// File: rtl/hbmf_sat_counter.sv
module hbmf_sat_counter #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         restart,
    output logic [W-1:0] count_q,
    output logic [W-1:0] count_now
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        count_now = (inc && st_q.count != MAX) ? st_q.count + W'(1) : st_q.count;
        st_d.count = restart ? '0 : count_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_q = st_q.count;

    // R6: tally restarts after a strobe
    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart) |-> count_q == '0);
    // R7: without a strobe the tally never falls (no wrap)
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(restart) |-> count_q >= $past(count_q));
endmodule

// File: rtl/hbmf_w1c_flag.sv
module hbmf_w1c_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic irq
);
    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.flag = 1'b0;
        if (set) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign irq  = st_q.flag & en;

    // R8: a flag falls only after a clear request
    a_r8_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr));
    // R8: set wins over a simultaneous clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set) |-> flag);
endmodule

// File: rtl/hbmf_checker.sv
module hbmf_checker
    import hbmf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_trans,
    input  logic             in_done,
    input  logic             in_underflow,
    input  logic             cpu_fill,
    input  logic             mf_end,
    input  logic             flush_clr,
    input  logic             uflerr_clr,
    input  logic             flush_en,
    input  logic             uflerr_en,
    output logic             flush_flag,
    output logic             uflerr_flag,
    output logic             bank_flush,
    output logic             ep_irq
);
    localparam int CMP_W = (CNT_W > CFG_W) ? CNT_W : CFG_W;

    logic [CNT_W-1:0] tx_q, tx_now, fill_q, fill_now;
    logic             tx_inc, armed, tx_short, fill_short;
    logic             set_flush, set_uflerr, irq_flush, irq_uflerr;
    top_state_t       st_d, st_q;

    assign tx_inc = in_done & ~in_underflow;
    assign armed  = cfg_armed(cfg_trans);

    hbmf_sat_counter #(.W(CNT_W)) i_tx_cnt (
        .clk(clk), .rst_n(rst_n), .inc(tx_inc), .restart(mf_end),
        .count_q(tx_q), .count_now(tx_now)
    );

    hbmf_sat_counter #(.W(CNT_W)) i_fill_cnt (
        .clk(clk), .rst_n(rst_n), .inc(cpu_fill), .restart(mf_end),
        .count_q(fill_q), .count_now(fill_now)
    );

    always_comb begin
        st_d       = st_q;
        tx_short   = CMP_W'(tx_now)   < CMP_W'(cfg_trans);
        fill_short = CMP_W'(fill_now) < CMP_W'(cfg_trans);
        set_flush  = mf_end & armed & tx_short;
        set_uflerr = mf_end & armed & fill_short;
        st_d.bank_flush = set_flush;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    hbmf_w1c_flag i_flush_flag (
        .clk(clk), .rst_n(rst_n), .set(set_flush), .clr(flush_clr),
        .en(flush_en), .flag(flush_flag), .irq(irq_flush)
    );

    hbmf_w1c_flag i_uflerr_flag (
        .clk(clk), .rst_n(rst_n), .set(set_uflerr), .clr(uflerr_clr),
        .en(uflerr_en), .flag(uflerr_flag), .irq(irq_uflerr)
    );

    assign bank_flush = st_q.bank_flush;
    assign ep_irq     = irq_flush | irq_uflerr;

    // R4: flush pulse only follows a strobe, and lasts one cycle
    a_r4_flush_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        bank_flush |-> $past(mf_end));
    a_r4_flush_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        bank_flush |-> flush_flag);
    // R2: an unarmed configuration never produces a flush or raises a flag
    a_r2_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
        bank_flush |-> cfg_armed($past(cfg_trans)));
    a_r2_no_rise_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flush_flag) || $rose(uflerr_flag)) |-> ($past(mf_end) && cfg_armed($past(cfg_trans))));
    // R9: no interrupt while both flags are clear
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ep_irq |-> (flush_flag || uflerr_flag));
    // R1: outputs are quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(!rst_n) |-> (!flush_flag && !uflerr_flag && !bank_flush));
endmodule

// File: tb/test_hbmf_checker.sv
module test_hbmf_checker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_trans = 2'd0;
    logic in_done = 0, in_underflow = 0, cpu_fill = 0, mf_end = 0;
    logic flush_clr = 0, uflerr_clr = 0, flush_en = 0, uflerr_en = 0;
    logic flush_flag, uflerr_flag, bank_flush, ep_irq;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hbmf_checker i_hbmf_checker (
        .clk(clk), .rst_n(rst_n), .cfg_trans(cfg_trans), .in_done(in_done),
        .in_underflow(in_underflow), .cpu_fill(cpu_fill), .mf_end(mf_end),
        .flush_clr(flush_clr), .uflerr_clr(uflerr_clr), .flush_en(flush_en),
        .uflerr_en(uflerr_en), .flush_flag(flush_flag), .uflerr_flag(uflerr_flag),
        .bank_flush(bank_flush), .ep_irq(ep_irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_all();
        flush_clr = 1; uflerr_clr = 1; tick();
        flush_clr = 0; uflerr_clr = 0; tick();
    endtask

    // d clean transactions, u underflowed ones, f CPU fills, then a strobe
    task automatic run_mf(input int d, input int u, input int f);
        for (int i = 0; i < 5; i++) begin
            in_done = (i < d + u); in_underflow = (i >= d) && (i < d + u);
            cpu_fill = (i < f);
            tick();
        end
        in_done = 0; in_underflow = 0; cpu_fill = 0;
        mf_end = 1; tick(); mf_end = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        // R1: reset state
        chk("R1 flush_flag", flush_flag, 0);
        chk("R1 uflerr_flag", uflerr_flag, 0);
        chk("R1 bank_flush", bank_flush, 0);
        chk("R1 ep_irq", ep_irq, 0);
        rst_n = 1; tick();
        chk("R1 after release", flush_flag | uflerr_flag | bank_flush, 0);

        // Sweep: R2, R3, R4, R5, R7, R9
        for (int c = 0; c < 4; c++) begin
            for (int d = 0; d < 5; d++) begin
                for (int u = 0; u < 2; u++) begin
                    for (int f = 0; f < 5; f++) begin
                        automatic bit armed = (c >= 2);
                        automatic int good = (d > 3) ? 3 : d;
                        automatic int fl = (f > 3) ? 3 : f;
                        automatic bit ex_f = armed && (good < c);
                        automatic bit ex_u = armed && (fl < c);
                        cfg_trans = 2'(c);
                        flush_en = d[0]; uflerr_en = f[0] ^ u[0];
                        run_mf(d, u, f);
                        chk("R4 R3 R7 R2 bank_flush pulse", bank_flush, ex_f);
                        chk("R4 R3 R7 R2 flush_flag", flush_flag, ex_f);
                        chk("R5 R7 R2 uflerr_flag", uflerr_flag, ex_u);
                        chk("R9 ep_irq", ep_irq, (ex_f & flush_en) | (ex_u & uflerr_en));
                        tick();
                        chk("R4 single-cycle bank_flush", bank_flush, 0);
                        chk("R8 flush_flag holds", flush_flag, ex_f);
                        clear_all();
                        chk("R8 cleared", flush_flag | uflerr_flag, 0);
                    end
                end
            end
        end

        // R6: events in the strobe cycle count, then tallies restart
        cfg_trans = 2'd2; flush_en = 1; uflerr_en = 1;
        in_done = 1; cpu_fill = 1; tick();
        mf_end = 1; tick();
        mf_end = 0; in_done = 0; cpu_fill = 0;
        chk("R6 same-cycle event counted (flush)", flush_flag, 0);
        chk("R6 same-cycle event counted (uflerr)", uflerr_flag, 0);
        tick();
        in_done = 1; cpu_fill = 1; tick(); in_done = 0; cpu_fill = 0;
        mf_end = 1; tick(); mf_end = 0;
        chk("R6 restart from zero (flush)", flush_flag, 1);
        chk("R6 restart from zero (uflerr)", uflerr_flag, 1);
        tick();

        // R8: clearing one flag leaves the other
        flush_clr = 1; tick(); flush_clr = 0;
        chk("R8 flush cleared", flush_flag, 0);
        chk("R8 uflerr kept", uflerr_flag, 1);
        chk("R9 irq from uflerr only", ep_irq, 1);
        uflerr_en = 0; tick();
        chk("R9 irq masked", ep_irq, 0);
        clear_all();

        // R8: set wins over simultaneous clear
        cfg_trans = 2'd3; flush_clr = 1; uflerr_clr = 1; mf_end = 1; tick();
        mf_end = 0; flush_clr = 0; uflerr_clr = 0;
        chk("R8 set wins (flush)", flush_flag, 1);
        chk("R8 set wins (uflerr)", uflerr_flag, 1);
        clear_all();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule